// File: doc/BRIEF.md
# Eight-Line Programmable Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a host processor. The host reaches it through a byte-wide port with two addresses. Address 0 takes commands and returns either the pending-request or the in-service register. Address 1 loads and returns the mask. Line 0 has the highest priority and line 7 the lowest. While an interrupt is outstanding, the host answers it with a one-cycle acknowledge strobe. In that same cycle the block drives an 8-bit vector, and the served request moves from pending into service.

After reset, the host programs the block with a short init sequence. It first writes an init command to address 0. It then writes up to three configuration bytes to address 1: a vector base, a cascade-line mask and a mode byte. After that, host commands end service on one specific line or choose which register address 0 returns. An optional automatic end-of-service mode removes the need for those end commands.

If a request has gone away by the time it is acknowledged, the block reports a spurious interrupt on the lowest-priority line. For a cascade arrangement, the block raises a flag when it acknowledges a line that has a downstream controller.

Top module: `pic8_ctrl`

## Requirements
- R1: A command-address write with bit 4 set starts initialization. The next data-address writes are taken in order as the vector base, the cascade mask and the mode byte. The cascade-mask step is skipped when bit 1 of the init command is 1 (single mode). The mode-byte step is skipped when bit 0 is 0, and automatic end-of-service is then off.
- R2: The vector driven during acknowledge is the programmed base plus the number of the line being served, modulo 256.
- R3: Priority is fixed, with line 0 highest. `int_out` is high only while some pending, unmasked request has a lower line number than every line currently in service.
- R4: A rising edge on `irq_in[n]` sets pending bit n. The pending bit clears if the input falls before it is acknowledged. An acknowledge clears the winning pending bit and, without automatic end-of-service, sets in-service bit n.
- R5: A command write of 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R6: A command write of 0x0A makes command-address reads return the pending register. A write of 0x0B makes them return the in-service register. The choice persists across reads until changed, and starting initialization resets it to the pending register.
- R7: A data-address write made outside an init sequence loads the mask. A data-address read returns the mask, and mask bit n = 1 blocks line n from raising `int_out`.
- R8: An acknowledge that arrives with no request eligible to win returns base+7 and leaves the in-service register unchanged. This holds even when line 7 is masked.
- R9: When bit 1 of the mode byte is 1 (automatic end-of-service), an acknowledge sets no in-service bit.
- R10: Starting initialization clears the mask and the in-service register. Data-address writes consumed by the init sequence never change the mask.
- R11: `cascade_hit` is high during an acknowledge only when the winning line's bit is set in the cascade mask, the block is in cascaded mode and `slave_attached` is high.
- R12: After reset, the mask is 0xFF, the pending and in-service registers are 0, `int_out` is low, command reads select the pending register and the vector base is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_addr | input | 1 | 0 selects the command address, 1 selects the data/mask address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the address on `host_addr` (combinational) |
| irq_in | input | 8 | Request lines, edge-detected |
| slave_attached | input | 1 | High when a downstream controller is present |
| int_ack | input | 1 | One-cycle acknowledge strobe from the host |
| int_out | output | 1 | Interrupt output to the host |
| ack_vector | output | 8 | Vector valid in the acknowledge cycle |
| cascade_hit | output | 1 | The acknowledged line feeds a downstream controller |

## Verification
The spurious case is the hardest to reach. It needs a request that was once pending and has since been withdrawn, so the stimulus raises a line, confirms `int_out`, drops the line and only then strobes acknowledge. It does this once with line 7 unmasked and once with line 7 masked. Nesting is reached by acknowledging a low-priority line and then raising a higher one while the first is still in service. A sweep over every ordered pair of lines confirms that the lower-numbered line wins, that the loser is held off until the winner is released, and that the loser is then served.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int LINES = 8;
    localparam int IDW   = $clog2(LINES);
    localparam int DW    = 8;

    // command decode fields
    localparam int        INIT_BIT     = 4;
    localparam int        SELCMD_BIT   = 3;
    localparam logic [4:0] EOI_TAG     = 5'b01100;
    localparam logic [DW-1:0] MASK_RESET = '1;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_BASE,
        ST_CASC,
        ST_MODE
    } init_st_e;

    typedef struct packed {
        logic [DW-1:0]    base;
        logic [LINES-1:0] casc_mask;
        logic             single;
        logic             need_mode;
        logic             auto_eoi;
    } cfg_t;

    typedef struct packed {
        logic           valid;
        logic [IDW-1:0] id;
    } pick_t;

    function automatic pick_t pick_lowest(input logic [LINES-1:0] v);
        pick_t p;
        p = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.id    = IDW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [LINES-1:0] line_bit(input logic [IDW-1:0] id);
        return LINES'(1) << id;
    endfunction
endpackage

// File: rtl/pic8_host_regs.sv
module pic8_host_regs
    import pic8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_wr,
    input  logic                 host_addr,
    input  logic [DW-1:0]        host_wdata,
    output cfg_t                 cfg,
    output logic [LINES-1:0]     imr,
    output logic                 rsel_isr,
    output logic                 init_pulse,
    output logic                 eoi_valid,
    output logic [IDW-1:0]       eoi_id
);
    init_st_e st;

    logic cmd_wr, dat_wr;
    assign cmd_wr     = host_wr && !host_addr;
    assign dat_wr     = host_wr &&  host_addr;
    assign init_pulse = cmd_wr && host_wdata[INIT_BIT];
    assign eoi_valid  = cmd_wr && (host_wdata[7:3] == EOI_TAG);
    assign eoi_id     = host_wdata[IDW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_RUN;
            cfg      <= '0;
            imr      <= MASK_RESET;
            rsel_isr <= 1'b0;
        end else if (init_pulse) begin
            st            <= ST_BASE;
            cfg.single    <= host_wdata[1];
            cfg.need_mode <= host_wdata[0];
            cfg.auto_eoi  <= 1'b0;
            imr           <= '0;
            rsel_isr      <= 1'b0;
        end else if (cmd_wr) begin
            if (!host_wdata[INIT_BIT] && host_wdata[SELCMD_BIT] && host_wdata[1])
                rsel_isr <= host_wdata[0];
        end else if (dat_wr) begin
            unique case (st)
                ST_RUN:  imr <= host_wdata;
                ST_BASE: begin
                    cfg.base <= host_wdata;
                    if (!cfg.single)        st <= ST_CASC;
                    else if (cfg.need_mode) st <= ST_MODE;
                    else                    st <= ST_RUN;
                end
                ST_CASC: begin
                    cfg.casc_mask <= host_wdata;
                    st <= cfg.need_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    cfg.auto_eoi <= host_wdata[1];
                    st <= ST_RUN;
                end
                default: st <= ST_RUN;
            endcase
        end
    end

    assert_init_enter_R1: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> (st == ST_BASE));
    assert_init_mask_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !init_pulse && st != ST_RUN) |=> $stable(imr));
    assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && st == ST_RUN) |=> (imr == $past(host_wdata)));
endmodule

// File: rtl/pic8_req_latch.sv
module pic8_req_latch
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] irq_in,
    input  logic             take,
    input  logic [IDW-1:0]   take_id,
    output logic [LINES-1:0] irr
);
    logic [LINES-1:0] prev;
    logic [LINES-1:0] clr;

    assign clr = take ? line_bit(take_id) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            irr  <= ((irr & ~clr) | (irq_in & ~prev)) & irq_in;
        end
    end

    assert_pending_needs_level_R4: assert property (@(posedge clk) disable iff (rst)
        ((irr & ~$past(irq_in)) == '0));
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio
    import pic8_pkg::*;
(
    input  logic [LINES-1:0] irr,
    input  logic [LINES-1:0] imr,
    input  logic [LINES-1:0] isr,
    output pick_t            win,
    output logic             int_req
);
    pick_t svc;

    always_comb begin
        win     = pick_lowest(irr & ~imr);
        svc     = pick_lowest(isr);
        int_req = win.valid && (!svc.valid || (win.id < svc.id));
    end
endmodule

// File: rtl/pic8_in_service.sv
module pic8_in_service
    import pic8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init_clear,
    input  logic             take,
    input  logic [IDW-1:0]   take_id,
    input  logic             auto_eoi,
    input  logic             eoi_valid,
    input  logic [IDW-1:0]   eoi_id,
    output logic [LINES-1:0] isr
);
    logic [LINES-1:0] set_m, clr_m;

    assign set_m = (take && !auto_eoi) ? line_bit(take_id) : '0;
    assign clr_m = eoi_valid ? line_bit(eoi_id) : '0;

    always_ff @(posedge clk) begin
        if (rst || init_clear) isr <= '0;
        else                   isr <= (isr & ~clr_m) | set_m;
    end

    assert_eoi_single_bit_R5: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !take && !init_clear) |=>
            (isr == ($past(isr) & ~line_bit($past(eoi_id)))));
    assert_ack_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !auto_eoi && !init_clear) |=> isr[$past(take_id)]);
endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic          host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic [7:0]    irq_in,
    input  logic          slave_attached,
    input  logic          int_ack,
    output logic          int_out,
    output logic [7:0]    ack_vector,
    output logic          cascade_hit
);
    cfg_t             cfg;
    logic [LINES-1:0] imr, irr, isr;
    logic             rsel_isr, init_pulse, eoi_valid;
    logic [IDW-1:0]   eoi_id;
    pick_t            win;
    logic             int_req, take;
    logic [IDW-1:0]   served_id;

    pic8_host_regs u_regs (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .cfg(cfg), .imr(imr), .rsel_isr(rsel_isr),
        .init_pulse(init_pulse), .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    pic8_req_latch u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .take(take),
        .take_id(win.id), .irr(irr)
    );

    pic8_prio u_prio (
        .irr(irr), .imr(imr), .isr(isr), .win(win), .int_req(int_req)
    );

    pic8_in_service u_isr (
        .clk(clk), .rst(rst), .init_clear(init_pulse), .take(take),
        .take_id(win.id), .auto_eoi(cfg.auto_eoi), .eoi_valid(eoi_valid),
        .eoi_id(eoi_id), .isr(isr)
    );

    assign take        = int_ack && int_req;
    assign served_id   = int_req ? win.id : IDW'(LINES - 1);
    assign ack_vector  = cfg.base + DW'(served_id);
    assign cascade_hit = take && !cfg.single && cfg.casc_mask[win.id] && slave_attached;
    assign int_out     = int_req;
    assign host_rdata  = host_addr ? imr : (rsel_isr ? isr : irr);

    assert_out_needs_unmasked_R3: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~imr) != '0));
    assert_spurious_no_isr_R8: assert property (@(posedge clk) disable iff (rst)
        (int_ack && !int_req && !eoi_valid && !init_pulse) |=> $stable(isr));
    assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (rst)
        (int_ack && cfg.auto_eoi && !eoi_valid && !init_pulse) |=> $stable(isr));
    assert_init_clears_R10: assert property (@(posedge clk) disable iff (rst)
        init_pulse |=> (imr == '0 && isr == '0));
    assert_cascade_gate_R11: assert property (@(posedge clk) disable iff (rst)
        cascade_hit |-> (int_ack && slave_attached));
endmodule

// File: tb/pic8_ctrl_tb_top.sv
module pic8_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_addr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] irq_in = '0;
    logic       slave_attached = 1'b1;
    logic       int_ack = 1'b0;
    logic       int_out;
    logic [7:0] ack_vector;
    logic       cascade_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pic8_ctrl dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
        .slave_attached(slave_attached), .int_ack(int_ack), .int_out(int_out),
        .ack_vector(ack_vector), .cascade_hit(cascade_hit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic ack(output logic [7:0] v, output logic ch);
        @(negedge clk);
        int_ack = 1'b1;
        #1;
        v = ack_vector; ch = cascade_hit;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        logic ch;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        rd(1'b1, d); chk("R12 mask", d, 8'hFF);
        rd(1'b0, d); chk("R12 pending", d, 0);
        chk("R12 int_out", int_out, 0);
        wr(1'b0, 8'h0B); rd(1'b0, d); chk("R12 in-service", d, 0);
        wr(1'b0, 8'h0A);

        // R1/R10 standard init: edge, cascaded, mode byte needed
        wr(1'b0, 8'h11);
        rd(1'b1, d); chk("R10 mask cleared", d, 0);
        wr(1'b1, 8'h20); rd(1'b1, d); chk("R10 base write keeps mask", d, 0);
        wr(1'b1, 8'h04); rd(1'b1, d); chk("R10 cascade write keeps mask", d, 0);
        wr(1'b1, 8'h01); rd(1'b1, d); chk("R10 mode write keeps mask", d, 0);

        // R7 mask load and readback
        wr(1'b1, 8'hA5); rd(1'b1, d); chk("R7 mask readback", d, 8'hA5);
        wr(1'b1, 8'h00); rd(1'b1, d); chk("R7 mask cleared", d, 0);

        // single-line sweep
        for (int n = 0; n < 8; n++) begin
            set_irq(8'(1 << n));
            chk("R3 int_out single", int_out, 1);
            rd(1'b0, d); chk("R4 pending set", d, 1 << n);
            ack(v, ch);
            chk("R2 vector", v, 8'h20 + n);
            chk("R11 cascade flag", ch, (n == 2) ? 1 : 0);
            rd(1'b0, d); chk("R4 pending cleared by ack", d, 0);
            set_irq(8'h00);
            wr(1'b0, 8'h0B);
            rd(1'b0, d); chk("R6 in-service select", d, 1 << n);
            rd(1'b0, d); chk("R6 select persists", d, 1 << n);
            chk("R3 no int while served", int_out, 0);
            wr(1'b0, 8'(8'h60 + n));
            rd(1'b0, d); chk("R5 eoi clears", d, 0);
            wr(1'b0, 8'h0A);
        end

        // R11 no cascade flag without slave
        slave_attached = 1'b0;
        set_irq(8'h04); ack(v, ch);
        chk("R11 no slave", ch, 0);
        set_irq(8'h00); wr(1'b0, 8'h62);
        slave_attached = 1'b1;

        // pair sweep: lower line wins, other held off until release
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a != b) begin
                    int lo, hi;
                    lo = (a < b) ? a : b;
                    hi = (a < b) ? b : a;
                    set_irq(8'((1 << a) | (1 << b)));
                    ack(v, ch);
                    chk("R3 pair winner", v, 8'h20 + lo);
                    chk("R3 loser held off", int_out, 0);
                    wr(1'b0, 8'(8'h60 + lo));
                    chk("R3 loser released", int_out, 1);
                    ack(v, ch);
                    chk("R2 loser vector", v, 8'h20 + hi);
                    wr(1'b0, 8'(8'h60 + hi));
                    set_irq(8'h00);
                end
            end
        end

        // nesting and specific eoi clearing only one bit
        set_irq(8'h20); ack(v, ch);
        chk("R2 nest outer", v, 8'h25);
        set_irq(8'h22);
        chk("R3 higher preempts", int_out, 1);
        ack(v, ch);
        chk("R2 nest inner", v, 8'h21);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R4 nested in-service", d, 8'h22);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R5 eoi one bit", d, 8'h20);
        wr(1'b0, 8'h65);
        rd(1'b0, d); chk("R5 eoi last", d, 0);
        wr(1'b0, 8'h0A);
        set_irq(8'h00);

        // R7 mask blocking
        wr(1'b1, 8'h08);
        set_irq(8'h08);
        chk("R7 masked no int", int_out, 0);
        rd(1'b0, d); chk("R7 masked still pending", d, 8'h08);
        wr(1'b1, 8'h00);
        chk("R7 unmask raises", int_out, 1);
        ack(v, ch); chk("R7 vector after unmask", v, 8'h23);
        wr(1'b0, 8'h63); set_irq(8'h00);

        // R4/R8 spurious: request withdrawn before ack
        set_irq(8'h10);
        chk("R4 int before drop", int_out, 1);
        set_irq(8'h00);
        chk("R4 drop clears", int_out, 0);
        ack(v, ch);
        chk("R8 spurious vector", v, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 no in-service", d, 0);
        wr(1'b0, 8'h0A);
        wr(1'b1, 8'h80);
        set_irq(8'h01); set_irq(8'h00);
        ack(v, ch);
        chk("R8 spurious with line7 masked", v, 8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R8 masked no in-service", d, 0);

        // R10/R6/R1: re-init in single mode with auto eoi, in-service non-empty
        wr(1'b1, 8'h00);
        set_irq(8'h10); ack(v, ch); set_irq(8'h00);
        rd(1'b0, d); chk("R4 service before reinit", d, 8'h10);
        wr(1'b1, 8'h33);
        wr(1'b0, 8'h13);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R1 cascade step skipped", d, 0);
        set_irq(8'h40);
        rd(1'b0, d); chk("R6 init resets select", d, 8'h40);
        ack(v, ch);
        chk("R2 new base", v, 8'h46);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 init cleared service", d, 0);
        set_irq(8'h00);
        set_irq(8'h04); ack(v, ch);
        chk("R11 single mode no cascade", ch, 0);
        chk("R2 line2 vector", v, 8'h42);
        rd(1'b0, d); chk("R9 auto eoi", d, 0);
        set_irq(8'h00);

        // R1: init without mode byte, cascade mask taken, auto eoi off
        wr(1'b0, 8'h10);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R1 mode step skipped", d, 0);
        set_irq(8'h02); ack(v, ch);
        chk("R1 base 08 vector", v, 8'h09);
        chk("R11 mask bit1 cascade", ch, 1);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R1 auto eoi off", d, 8'h02);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule